// File: doc/BRIEF.md
# GPIO Expander Port and Interrupt Core

This block is the digital heart of a general-purpose I/O expander. A host reaches it through a simple synchronous register interface with an address, write data, a write strobe, a read strobe and combinational read data. Through it the host sets, for each pin on its own, whether the pin is an input or an output. It also sets the value driven on output pins, a read inversion mask, a mask for interrupt sources, and the pad control settings: keeper (bus-hold) or resistor pull, and the pull direction.

Pin levels first pass through a two-stage synchronizer. The host reads them through the per-bit inversion mask. A change on an unmasked input pin, measured against the level the host last read, raises an active-low interrupt. The interrupt leaves the block as a low level plus a drive enable, so that several such blocks can share one wired-AND line. A strobed read of the input register or of the status register takes a new reference level and clears the interrupt. The interrupt also clears by itself when the pins go back to the reference level.

Top module: `gpio_port_core`

## Requirements
- R1: After reset the direction register reads 0xFF (1 = input), the mask register reads 0xFF (1 = masked), and the inversion, keeper, pull-select and output registers read 0x00. pin_oe is 0x00, int_n is 1 and int_oe is 0.
- R2: Register addresses: 0 input (read-only), 1 inversion, 2 keeper enable, 3 pull select, 4 direction, 5 output value, 6 interrupt mask, 7 interrupt status (read-only). A write to 1..6 takes effect at the clock edge and reads back unchanged. A write to 0 or 7 changes nothing.
- R3: pin_oe bit i is the inverse of direction bit i. pin_out bit i equals output bit i when the pin is an output, and is 0 otherwise.
- R4: Reading address 0 returns the pin level XOR the inversion register. A pin change appears there after the second clock edge following the change, and not after the first.
- R5: A change on an unmasked input pin, relative to the reference level, sets its status bit after the third clock edge. At that point int_n is 0 and int_oe is 1.
- R6: A change on a masked pin sets no status bit and leaves int_n at 1.
- R7: A change on a pin configured as an output sets no status bit.
- R8: A read strobe on address 0 or 7 captures the current synchronized level as the new reference. The status clears at that same edge.
- R9: If the pin returns to the reference level, its status bit clears three edges after the return, with no read.
- R10: When keeper bit i is 1, hold_en bit i is 1 and pull_en and pull_up bit i are 0. When it is 0, pull_en bit i is 1 and pull_up bit i equals pull-select bit i (1 = pull-up).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (captures reference on addresses 0 and 7) |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| hold_en | output | 8 | Per-pin keeper enable |
| pull_en | output | 8 | Per-pin pull resistor enable |
| pull_up | output | 8 | Per-pin pull direction (1 = up) |
| int_n | output | 1 | Interrupt level, active low |
| int_oe | output | 1 | Drive enable for int_n (open-drain model) |

## Verification
Register writes and pad controls take effect at the edge on which the write strobe is sampled. The bench therefore samples them at the following falling edge. The input read is due two edges after a pin change and the interrupt three edges after it. Each timing check samples once at the falling edge before the due edge, where the old value is expected, and once at the falling edge after it. Clear-on-read is checked at the falling edge right after the strobed read. Clear-on-return is checked three edges after the pin goes back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned PORT_W = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_INPUT = 3'd0,
        A_INV   = 3'd1,
        A_KEEP  = 3'd2,
        A_PSEL  = 3'd3,
        A_DIR   = 3'd4,
        A_OUT   = 3'd5,
        A_MASK  = 3'd6,
        A_STAT  = 3'd7
    } gpio_addr_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_tracker.sv
module gpio_irq_tracker #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] watch_i,
    input  logic         capture_i,
    output logic [W-1:0] pending_o
);
    typedef struct packed {
        logic [W-1:0] ref_lvl;
        logic [W-1:0] pend;
    } trk_t;

    trk_t t_d, t_q;

    always_comb begin
        t_d         = t_q;
        t_d.ref_lvl = capture_i ? level_i : t_q.ref_lvl;
        t_d.pend    = (level_i ^ t_d.ref_lvl) & watch_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pending_o = t_q.pend;

    // R8
    clear_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (pending_o == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] keep_i,
    input  logic [W-1:0] psel_i,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] out_o,
    output logic [W-1:0] hold_o,
    output logic [W-1:0] pen_o,
    output logic [W-1:0] pup_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pad
            always_comb begin
                oe_o[i]   = ~dir_i[i];
                out_o[i]  = val_i[i] & ~dir_i[i];
                hold_o[i] = keep_i[i];
                pen_o[i]  = ~keep_i[i];
                pup_o[i]  = psel_i[i] & ~keep_i[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [W-1:0]      reg_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      hold_en,
    output logic [W-1:0]      pull_en,
    output logic [W-1:0]      pull_up,
    output logic              int_n,
    output logic              int_oe
);
    localparam logic [W-1:0] DIR_RST  = '1;
    localparam logic [W-1:0] MASK_RST = '1;

    typedef struct packed {
        logic [W-1:0] inv;
        logic [W-1:0] keep;
        logic [W-1:0] psel;
        logic [W-1:0] dir;
        logic [W-1:0] val;
        logic [W-1:0] mask;
    } regs_t;

    localparam regs_t REGS_RST = '{inv: '0, keep: '0, psel: '0,
                                   dir: DIR_RST, val: '0, mask: MASK_RST};

    regs_t      r_d, r_q;
    gpio_addr_e addr;
    logic [W-1:0] lvl_sync;
    logic [W-1:0] pend;
    logic         capture;

    assign addr    = gpio_addr_e'(reg_addr);
    assign capture = reg_rd && (addr == A_INPUT || addr == A_STAT);

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (addr)
                A_INV:   r_d.inv  = reg_wdata;
                A_KEEP:  r_d.keep = reg_wdata;
                A_PSEL:  r_d.psel = reg_wdata;
                A_DIR:   r_d.dir  = reg_wdata;
                A_OUT:   r_d.val  = reg_wdata;
                A_MASK:  r_d.mask = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            A_INPUT: reg_rdata = lvl_sync ^ r_q.inv;
            A_INV:   reg_rdata = r_q.inv;
            A_KEEP:  reg_rdata = r_q.keep;
            A_PSEL:  reg_rdata = r_q.psel;
            A_DIR:   reg_rdata = r_q.dir;
            A_OUT:   reg_rdata = r_q.val;
            A_MASK:  reg_rdata = r_q.mask;
            default: reg_rdata = pend;
        endcase
    end

    gpio_pin_sync #(.W(W), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (lvl_sync)
    );

    gpio_irq_tracker #(.W(W)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (lvl_sync),
        .watch_i   (r_q.dir & ~r_q.mask),
        .capture_i (capture),
        .pending_o (pend)
    );

    gpio_pad_ctrl #(.W(W)) pad_i (
        .dir_i  (r_q.dir),
        .val_i  (r_q.val),
        .keep_i (r_q.keep),
        .psel_i (r_q.psel),
        .oe_o   (pin_oe),
        .out_o  (pin_out),
        .hold_o (hold_en),
        .pen_o  (pull_en),
        .pup_o  (pull_up)
    );

    assign int_n  = ~(|pend);
    assign int_oe = |pend;

    // R10
    keeper_pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en & pull_en) == '0);

    // R3
    out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mask == '1) |=> int_n);

    // R7
    out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.dir == '0) |=> (pend == '0));
endmodule

// File: tb/gpio_port_core_tb.sv
module gpio_port_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_oe, pin_out, hold_en, pull_en, pull_up;
    logic       int_n, int_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    gpio_port_core dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .hold_en(hold_en), .pull_en(pull_en),
        .pull_up(pull_up), .int_n(int_n), .int_oe(int_oe)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_strobe(input logic [2:0] a);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(3'd4, v); check("R1 dir", v, 8'hFF);
        peek(3'd6, v); check("R1 mask", v, 8'hFF);
        peek(3'd1, v); check("R1 inv", v, 8'h00);
        peek(3'd2, v); check("R1 keep", v, 8'h00);
        peek(3'd3, v); check("R1 psel", v, 8'h00);
        peek(3'd5, v); check("R1 out", v, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 int", {6'd0, int_n, int_oe}, 8'h02);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        for (int a = 1; a <= 6; a++) wr(3'(a), 8'(8'h11 * a));
        for (int a = 1; a <= 6; a++) begin
            peek(3'(a), v); check("R2 readback", v, 8'(8'h11 * a));
        end
        wr(3'd0, 8'hFF); wr(3'd7, 8'hFF);
        peek(3'd0, v); check("R2 input ro", v, 8'h11);
        peek(3'd7, v); check("R2 status ro", v, 8'h00);
        for (int a = 1; a <= 6; a++) begin
            peek(3'(a), v); check("R2 no alias", v, 8'(8'h11 * a));
        end
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd4, 8'hFF); wr(3'd5, 8'h00); wr(3'd6, 8'hFF);
    endtask

    task automatic t_pads();
        wr(3'd4, 8'h0F); wr(3'd5, 8'hA5);
        check("R3 oe", pin_oe, 8'hF0);
        check("R3 out", pin_out, 8'hA0);
        wr(3'd4, 8'hFF);
        check("R3 out all inputs", pin_out, 8'h00);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_input();
        logic [7:0] v;
        wr(3'd1, 8'h0F);
        pin_in = 8'h3C;
        edges(1);
        peek(3'd0, v); check("R4 after 1 edge", v, 8'h0F);
        edges(1);
        peek(3'd0, v); check("R4 after 2 edges", v, 8'h33);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        rd_strobe(3'd0);
        wr(3'd6, 8'h00);
        check("R5 idle", {7'd0, int_n}, 8'h01);
        pin_in = 8'h3D;
        edges(2);
        check("R5 not yet", {7'd0, int_n}, 8'h01);
        edges(1);
        check("R5 int", {6'd0, int_n, int_oe}, 8'h01);
        peek(3'd7, v); check("R5 status", v, 8'h01);
        rd_strobe(3'd7);
        peek(3'd7, v); check("R8 status cleared", v, 8'h00);
        check("R8 int released", {6'd0, int_n, int_oe}, 8'h02);
    endtask

    task automatic t_return();
        logic [7:0] v;
        pin_in = 8'h3F;
        edges(3);
        peek(3'd7, v); check("R9 set", v, 8'h02);
        pin_in = 8'h3D;
        edges(3);
        peek(3'd7, v); check("R9 cleared", v, 8'h00);
        check("R9 int", {7'd0, int_n}, 8'h01);
    endtask

    task automatic t_masked();
        logic [7:0] v;
        wr(3'd6, 8'hFE);
        pin_in = 8'h1D;
        edges(4);
        peek(3'd7, v); check("R6 status", v, 8'h00);
        check("R6 int", {7'd0, int_n}, 8'h01);
        pin_in = 8'h3D;
        edges(3);
    endtask

    task automatic t_outpin();
        logic [7:0] v;
        wr(3'd4, 8'hFE); wr(3'd6, 8'h00);
        pin_in = 8'h3C;
        edges(4);
        peek(3'd7, v); check("R7 status", v, 8'h00);
        check("R7 int", {7'd0, int_n}, 8'h01);
        wr(3'd6, 8'hFF); wr(3'd4, 8'hFF);
    endtask

    task automatic t_pull();
        wr(3'd2, 8'h0F); wr(3'd3, 8'h33);
        check("R10 hold", hold_en, 8'h0F);
        check("R10 pull_en", pull_en, 8'hF0);
        check("R10 pull_up", pull_up, 8'h30);
        wr(3'd2, 8'h00);
        check("R10 no keeper", pull_up, 8'h33);
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_regmap();
        t_pads();
        t_input();
        t_irq();
        t_return();
        t_masked();
        t_outpin();
        t_pull();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule